// File: doc/BRIEF.md
# UART Byte FIFO Pair with Trigger Interrupts

This block holds the two byte queues of one UART channel. The transmit queue is filled by the host and drained by the transmit shift register. The receive queue is filled by the receive shift register and drained by the host. Both queues are 32 bytes deep. One 8-bit control write sets four things:
- the enable;
- the self-clearing pointer resets;
- DMA signalling;
- the two trigger selections.

The transmit selection is only taken while a separate enhanced-feature input is high.

From the two occupancy counts and the selected thresholds, the block derives a receive-data interrupt and a transmit-ready interrupt. The receive side reports "enough data waiting". The transmit side reports "room to reload", either once the level drops below the threshold after having reached it, or once the queue runs dry when it never did. The two active-low ready outputs change meaning with the DMA bit. Interrupts and ready outputs are decoded from registered state and follow the level outputs in the same cycle.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue holds 32 bytes, delivers them in write order, and reports its occupancy on its level output one cycle after a push or pop edge.
- R2: A push into a full queue is dropped, the level stays 32, and that queue's overrun output goes high and stays high. A pop from an empty queue leaves the data output at its last value and the level at 0.
- R3: A control write stores bit 0 as enable, bit 3 as DMA mode and bits 7:6 as the receive trigger select. The readback holds {7:6 receive select, 5:4 transmit select, 3 DMA, 2:1 zero, 0 enable}.
- R4: Control bits 5:4 (transmit trigger select) are stored only when `ext_en` is 1 during the write. Otherwise the previous selection is kept.
- R5: Control bit 1 clears the receive queue and bit 2 clears the transmit queue, together with each queue's overrun flag. A clear happens only if bit 0 is 1 in the same write, and it leaves the other queue untouched. Bits 2:1 always read back 0.
- R6: Receive select 00/01/10/11 gives a threshold of 8/16/24/28. `rx_irq` is high while enabled and the receive level is at or above the threshold.
- R7: Transmit select 00/01/10/11 gives a threshold of 16/8/24/30. Once the transmit level has reached the threshold, `tx_irq` rises when the level falls below it and drops when host writes raise it back to the threshold.
- R8: If the transmit level has not reached the threshold since the queue was last empty, `tx_irq` is high only while the queue is empty. This includes right after enabling.
- R9: In normal mode (DMA 0), `rx_rdy_n` is low while the receive queue holds any byte and `tx_rdy_n` is low while the transmit queue is empty.
- R10: In DMA mode, `rx_rdy_n` is low while `rx_irq` conditions hold and `tx_rdy_n` is low while the transmit queue is not full.
- R11: While disabled, pushes and pops are ignored and the contents are kept. Both interrupts are low and both ready outputs are high.
- R12: After reset all control fields are 0, both queues are empty, both overruns are 0, both interrupts are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ext_en | input | 1 | Enhanced-feature enable, gates transmit select |
| ctl_rdata | output | 8 | Control readback |
| host_tx_we | input | 1 | Host push into transmit queue |
| host_tx_data | input | 8 | Byte pushed by host |
| line_tx_re | input | 1 | Transmit shifter pop |
| line_tx_data | output | 8 | Byte popped for the transmit shifter |
| tx_level | output | 6 | Transmit queue occupancy |
| tx_ovr | output | 1 | Transmit queue overrun |
| line_rx_we | input | 1 | Receive shifter push |
| line_rx_data | input | 8 | Byte pushed by receive shifter |
| host_rx_re | input | 1 | Host pop from receive queue |
| host_rx_data | output | 8 | Byte popped for the host |
| rx_level | output | 6 | Receive queue occupancy |
| rx_ovr | output | 1 | Receive queue overrun |
| rx_irq | output | 1 | Receive-data interrupt |
| tx_irq | output | 1 | Transmit-ready interrupt |
| rx_rdy_n | output | 1 | Receive ready, active low |
| tx_rdy_n | output | 1 | Transmit ready, active low |

## Verification
A corrupted pointer shows up at the first pop after it, as a byte out of order on `host_rx_data` or `line_tx_data`. A corrupted count appears on the level port one cycle after the faulty edge, and with it a wrong interrupt or ready level. A lost or stuck transmit arming flag is visible only at a threshold crossing. For that reason the bench walks the transmit level across each chosen threshold in both directions, and also drains a queue that was never filled to its threshold.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic       en;
        logic       dma;
        logic [1:0] tx_sel;
        logic [1:0] rx_sel;
    } fctl_t;

    function automatic int unsigned rx_trig_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 24;
            default: return 28;
        endcase
    endfunction

    function automatic int unsigned tx_trig_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 16;
            2'b01:   return 8;
            2'b10:   return 24;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/ufp_byte_fifo.sv
module ufp_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] dout;
        logic             ovr;
    } fifo_st_t;

    fifo_st_t         s_q, s_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_push = 1'b0;
        do_pop  = 1'b0;
        if (clr) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
            s_d.ovr = 1'b0;
        end else if (en) begin
            do_pop = pop && (s_q.cnt != '0);
            if (push) begin
                if (s_q.cnt == CNT_W'(DEPTH)) s_d.ovr = 1'b1;
                else                          do_push = 1'b1;
            end
            if (do_push) s_d.wp = ptr_inc(s_q.wp);
            if (do_pop) begin
                s_d.dout = mem_q[s_q.rp];
                s_d.rp   = ptr_inc(s_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= push_data;
    end

    assign pop_data = s_q.dout;
    assign count    = s_q.cnt;
    assign overrun  = s_q.ovr;

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && push && !pop && count == CNT_W'(DEPTH)) |=>
        (count == CNT_W'(DEPTH) && overrun));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && pop && !push && count == '0) |=>
        ($stable(pop_data) && count == '0));

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(count) && $stable(pop_data)));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !overrun));

endmodule

// File: rtl/ufp_ctl.sv
module ufp_ctl
    import ufp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       ext_en,
    output fctl_t      ctl,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic [7:0] rdata
);

    fctl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (we) begin
            c_d.en     = wdata[0];
            c_d.dma    = wdata[3];
            c_d.rx_sel = wdata[7:6];
            if (ext_en) c_d.tx_sel = wdata[5:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rx_clr = we & wdata[0] & wdata[1];
    assign tx_clr = we & wdata[0] & wdata[2];
    assign ctl    = c_q;
    assign rdata  = {c_q.rx_sel, c_q.tx_sel, c_q.dma, 2'b00, c_q.en};

    // R4
    txsel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ext_en) |=> $stable(ctl.tx_sel));

    // R3
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl.en == $past(wdata[0]) && ctl.rx_sel == $past(wdata[7:6])));

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import ufp_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             ext_en,
    output logic [7:0]       ctl_rdata,
    input  logic             host_tx_we,
    input  logic [7:0]       host_tx_data,
    input  logic             line_tx_re,
    output logic [7:0]       line_tx_data,
    output logic [CNT_W-1:0] tx_level,
    output logic             tx_ovr,
    input  logic             line_rx_we,
    input  logic [7:0]       line_rx_data,
    input  logic             host_rx_re,
    output logic [7:0]       host_rx_data,
    output logic [CNT_W-1:0] rx_level,
    output logic             rx_ovr,
    output logic             rx_irq,
    output logic             tx_irq,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n
);

    typedef struct packed {
        logic tx_armed;
    } top_st_t;

    fctl_t            ctl;
    logic             rx_clr, tx_clr;
    logic [CNT_W-1:0] rx_trig, tx_trig;
    logic             rx_hit;
    top_st_t          t_q, t_d;

    ufp_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .ext_en (ext_en),
        .ctl    (ctl),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr),
        .rdata  (ctl_rdata)
    );

    ufp_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.en),
        .clr       (rx_clr),
        .push      (line_rx_we),
        .push_data (line_rx_data),
        .pop       (host_rx_re),
        .pop_data  (host_rx_data),
        .count     (rx_level),
        .overrun   (rx_ovr)
    );

    ufp_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.en),
        .clr       (tx_clr),
        .push      (host_tx_we),
        .push_data (host_tx_data),
        .pop       (line_tx_re),
        .pop_data  (line_tx_data),
        .count     (tx_level),
        .overrun   (tx_ovr)
    );

    always_comb begin
        rx_trig = CNT_W'(rx_trig_of(ctl.rx_sel));
        tx_trig = CNT_W'(tx_trig_of(ctl.tx_sel));
        rx_hit  = rx_level >= rx_trig;

        t_d = t_q;
        if (tx_level == '0)          t_d.tx_armed = 1'b0;
        else if (tx_level >= tx_trig) t_d.tx_armed = 1'b1;

        rx_irq   = ctl.en && rx_hit;
        tx_irq   = ctl.en && (t_q.tx_armed ? (tx_level < tx_trig) : (tx_level == '0));
        rx_rdy_n = !(ctl.en && (ctl.dma ? rx_hit : (rx_level != '0)));
        tx_rdy_n = !(ctl.en && (ctl.dma ? (tx_level != CNT_W'(DEPTH)) : (tx_level == '0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R8
    tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && tx_level == '0) |-> tx_irq);

    // R6
    rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && host_rx_re && !line_rx_we && !ctl_we && rx_level == rx_trig) |=> !rx_irq);

    // R7
    tx_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && host_tx_we && !line_tx_re && !ctl_we && tx_level == tx_trig - 1'b1) |=> !tx_irq);

    // R10
    dma_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && ctl.dma && tx_level == CNT_W'(DEPTH)) |-> tx_rdy_n);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |-> (!rx_irq && !tx_irq && rx_rdy_n && tx_rdy_n));

endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       ext_en = 1'b0;
    logic [7:0] ctl_rdata;
    logic       host_tx_we = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       line_tx_re = 1'b0;
    logic [7:0] line_tx_data;
    logic [5:0] tx_level;
    logic       tx_ovr;
    logic       line_rx_we = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic       host_rx_re = 1'b0;
    logic [7:0] host_rx_data;
    logic [5:0] rx_level;
    logic       rx_ovr, rx_irq, tx_irq, rx_rdy_n, tx_rdy_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] last_rx;
    event rx_pop_ev, tx_pop_ev;

    always #5 clk = ~clk;

    uart_fifo_pair u_uart_fifo_pair (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_wr(input logic [7:0] v, input logic x);
        ctl_we = 1'b1; ctl_wdata = v; ext_en = x;
        step();
        ctl_we = 1'b0; ext_en = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input bit keep);
        line_rx_we = 1'b1; line_rx_data = b;
        if (keep) rx_q.push_back(b);
        step();
        line_rx_we = 1'b0;
    endtask

    task automatic tx_push(input logic [7:0] b, input bit keep);
        host_tx_we = 1'b1; host_tx_data = b;
        if (keep) tx_q.push_back(b);
        step();
        host_tx_we = 1'b0;
    endtask

    task automatic rx_read(input bit cmp);
        host_rx_re = 1'b1;
        step();
        host_rx_re = 1'b0;
        if (cmp) begin ->rx_pop_ev; #1; end
    endtask

    task automatic tx_pull(input bit cmp);
        line_tx_re = 1'b1;
        step();
        line_tx_re = 1'b0;
        if (cmp) begin ->tx_pop_ev; #1; end
    endtask

    // scoreboard monitors
    initial forever begin
        @(rx_pop_ev);
        if (rx_q.size() == 0) chk("R1 rx queue underflow", 1, 0);
        else begin
            last_rx = rx_q.pop_front();
            chk("R1 rx order", int'(host_rx_data), int'(last_rx));
        end
    end

    initial forever begin
        @(tx_pop_ev);
        if (tx_q.size() == 0) chk("R1 tx queue underflow", 1, 0);
        else chk("R1 tx order", int'(line_tx_data), int'(tx_q.pop_front()));
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rx_level", rx_level, 0);
        chk("R12 tx_level", tx_level, 0);
        chk("R12 irqs", {rx_irq, tx_irq}, 0);
        chk("R12 rdy_n", {rx_rdy_n, tx_rdy_n}, 3);
        chk("R12 ctl_rdata", ctl_rdata, 0);
        chk("R12 ovr", {rx_ovr, tx_ovr}, 0);

        // R11 disabled push ignored
        rx_push(8'hAA, 0);
        chk("R11 push while disabled", rx_level, 0);

        // R4 transmit select blocked without ext_en
        ctl_wr(8'h31, 1'b0);
        chk("R4 tx_sel blocked", ctl_rdata, 8'h01);
        chk("R8 empty after enable", tx_irq, 1);
        chk("R9 tx_rdy_n empty", tx_rdy_n, 0);
        chk("R9 rx_rdy_n empty", rx_rdy_n, 1);
        ctl_wr(8'h31, 1'b1);
        chk("R3 readback", ctl_rdata, 8'h31);
        ctl_wr(8'h01, 1'b0);
        chk("R4 tx_sel kept", ctl_rdata, 8'h31);
        ctl_wr(8'h41, 1'b1);
        chk("R3 rx16 tx16", ctl_rdata, 8'h41);

        // R6 receive threshold 16
        for (int i = 0; i < 15; i++) rx_push(8'(i * 7 + 3), 1);
        chk("R1 rx_level 15", rx_level, 15);
        chk("R6 below 16", rx_irq, 0);
        chk("R9 rx_rdy_n data", rx_rdy_n, 0);
        rx_push(8'h5C, 1);
        chk("R6 at 16", rx_irq, 1);

        // R10 DMA mode
        ctl_wr(8'h49, 1'b0);
        chk("R3 dma readback", ctl_rdata, 8'h49);
        chk("R10 rx_rdy_n at trigger", rx_rdy_n, 0);
        chk("R10 tx_rdy_n not full", tx_rdy_n, 0);
        rx_read(1);
        chk("R6 drop below", rx_irq, 0);
        chk("R10 rx_rdy_n below", rx_rdy_n, 1);

        // R6 table at level 20 then 28
        for (int i = 0; i < 5; i++) rx_push(8'(8'hC0 + i), 1);
        ctl_wr(8'h09, 1'b0);
        chk("R6 sel00 level20", rx_irq, 1);
        ctl_wr(8'h89, 1'b0);
        chk("R6 sel10 level20", rx_irq, 0);
        ctl_wr(8'hC9, 1'b0);
        chk("R6 sel11 level20", rx_irq, 0);
        for (int i = 0; i < 8; i++) rx_push(8'(8'h90 + i), 1);
        chk("R6 sel11 level28", rx_irq, 1);

        // R2 overrun on full
        for (int i = 0; i < 4; i++) rx_push(8'(8'hE0 + i), 1);
        chk("R1 full level", rx_level, 32);
        rx_push(8'hFF, 0);
        chk("R2 dropped level", rx_level, 32);
        chk("R2 rx_ovr", rx_ovr, 1);

        // R1 drain in order
        ctl_wr(8'hC1, 1'b0);
        for (int i = 0; i < 32; i++) rx_read(1);
        chk("R1 rx empty", rx_level, 0);
        chk("R9 rx_rdy_n empty", rx_rdy_n, 1);
        rx_read(0);
        chk("R2 empty pop data", host_rx_data, last_rx);
        chk("R2 empty pop level", rx_level, 0);

        // R5 reset needs enable bit
        for (int i = 0; i < 3; i++) rx_push(8'(8'h30 + i), 1);
        tx_push(8'h11, 1);
        tx_push(8'h22, 1);
        ctl_wr(8'h02, 1'b0);
        chk("R5 readback no en", ctl_rdata, 8'h00);
        chk("R5 no clear without en", rx_level, 3);
        chk("R5 ovr kept", rx_ovr, 1);
        chk("R11 quiet", {rx_irq, tx_irq, rx_rdy_n, tx_rdy_n}, 4'b0011);
        rx_read(0);
        chk("R11 pop ignored", rx_level, 3);
        ctl_wr(8'h03, 1'b0);
        rx_q.delete();
        chk("R5 rx cleared", rx_level, 0);
        chk("R5 rx ovr cleared", rx_ovr, 0);
        chk("R5 tx untouched", tx_level, 2);
        chk("R5 bit1 reads 0", ctl_rdata, 8'h01);

        // R8 never reached threshold 16
        chk("R8 level2 no irq", tx_irq, 0);
        tx_pull(1);
        tx_pull(1);
        chk("R8 empty irq", tx_irq, 1);

        // R7 threshold 16
        for (int i = 0; i < 20; i++) tx_push(8'(i + 8'h40), 1);
        chk("R7 level20 no irq", tx_irq, 0);
        chk("R9 tx_rdy_n not empty", tx_rdy_n, 1);
        for (int i = 0; i < 4; i++) tx_pull(1);
        chk("R7 level16 no irq", tx_irq, 0);
        tx_pull(1);
        chk("R7 level15 irq", tx_irq, 1);
        tx_push(8'h77, 1);
        chk("R7 back to 16 clear", tx_irq, 0);

        // R7 threshold 30
        ctl_wr(8'h31, 1'b1);
        chk("R7 sel11 level16", tx_irq, 1);
        for (int i = 0; i < 14; i++) tx_push(8'(i + 8'h60), 1);
        chk("R7 level30 clear", tx_irq, 0);
        tx_pull(1);
        chk("R7 level29 irq", tx_irq, 1);
        for (int i = 0; i < 3; i++) tx_push(8'(i + 8'hA0), 1);
        tx_push(8'hEE, 0);
        chk("R2 tx dropped", tx_level, 32);
        chk("R2 tx_ovr", tx_ovr, 1);
        ctl_wr(8'h39, 1'b1);
        chk("R10 tx_rdy_n full", tx_rdy_n, 1);
        tx_pull(1);
        chk("R10 tx_rdy_n room", tx_rdy_n, 0);

        // R7 threshold 8
        ctl_wr(8'h19, 1'b1);
        for (int i = 0; i < 23; i++) tx_pull(1);
        chk("R7 level8 no irq", tx_irq, 0);
        tx_pull(1);
        chk("R7 level7 irq", tx_irq, 1);

        // R5 transmit clear
        ctl_wr(8'h05, 1'b0);
        tx_q.delete();
        chk("R5 tx cleared", tx_level, 0);
        chk("R5 tx ovr cleared", tx_ovr, 0);
        chk("R8 irq after clear", tx_irq, 1);

        report();
    end

endmodule